// File: doc/BRIEF.md
# Divided-Clock Countdown Timer

This block is a 32-bit down-counter paced by a programmable clock divider. Software programs three things: a divide configuration that picks a power-of-two division between 1 and 128, an initial count, and a control word. The control word carries an 8-bit vector, a mask bit and a periodic-mode bit. When the count runs out, the timer emits a single-cycle expiry pulse, and the vector from the control word comes out beside the pulse. In one-shot mode the timer then stops. In periodic mode it reloads and runs again.

The divider is a free-running 7-bit prescaler. A divided tick occurs in every cycle where the low `shift` bits of the prescaler are all ones. Writing the initial count loads the counter and clears the prescaler, so the timing of later ticks is fixed relative to that write. Writing the control word takes effect at once, and so does writing the divide configuration. Neither of those writes restarts the count.

The expiry output is an event with no back-pressure. The pulse is high for exactly one cycle and the vector is valid while it is high. There is no ready signal because the timer never waits. Register writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_sel`.

Top module: `tick_countdown`

## Requirements
- R1: After reset the divide configuration, the initial count and the current count all read 0. The control word has its mask set. No expiry pulse is produced.
- R2: A write with `wr_sel`=0 stores the divide configuration. Only data bits 0, 1 and 3 are kept, and `rd_sel`=0 reads it back with bit 2 and all bits above 3 read as zero. A write with `wr_sel`=3 changes nothing.
- R3: The divide shift is ((cfg[3]·4 + cfg[1:0]) + 1) mod 8. The divided tick period is 2^shift clock cycles. So a configuration of 0xB divides by 1 and a configuration of 0x0 divides by 2.
- R4: A write with `wr_sel`=1 loads the initial count and restarts timing from that edge. In the first cycle after the write, `rd_sel`=2 (current count) reads the written value and `rd_sel`=1 reads it back. The prescaler restarts from zero.
- R5: In one-shot mode (control bit 17 = 0), k cycles after an initial-count write with tick period P, the current count reads max(init − floor(k/P), 0).
- R6: In one-shot mode with a nonzero initial count, exactly one expiry pulse appears, in cycle k = (init+1)·P after the write.
- R7: In periodic mode (control bit 17 = 1) with a nonzero initial count, the current count reads init − (floor(k/P) mod (init+1)). A pulse appears in every cycle k = m·(init+1)·P, for m ≥ 1.
- R8: With an initial count of 0, no expiry is produced in either mode and the current count stays 0.
- R9: While control bit 16 (mask) is set, no expiry pulse is produced, but the count keeps running as in R5 and R7.
- R10: Each expiry pulse lasts one cycle. `expire_vector` then shows control bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divide cfg, 1 initial count, 2 control word, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 divide cfg, 1 initial count, 2 current count, 3 zero |
| rd_data | output | 32 | Combinational read data |
| expire_pulse | output | 1 | One-cycle expiry event |
| expire_vector | output | 8 | Vector carried with the expiry |

## Verification
The assertions check the following on every cycle:
- The expiry pulse never lasts two cycles.
- No pulse follows a cycle in which the mask was set.
- The count never rises except by a load or a periodic reload.
- A one-shot count that has reached zero stays at zero.
- The prescaler is zero right after an initial-count write.

Only the bench's scenarios can show the exact cycle of each expiry, the mapping from divide code to tick period, and the wrap period of init+1 ticks. The bench compares the current count and the pulse against closed-form expectations in every cycle of each run.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int VEC_W      = 8;
  localparam int SHIFT_W    = 3;
  localparam int DIVCFG_W   = 4;
  localparam logic [DIVCFG_W-1:0] DIV_KEEP = 4'hB;
  localparam int PERIODIC_BIT = 17;
  localparam int MASK_BIT     = 16;

  typedef enum logic [1:0] {
    WR_DIV  = 2'd0,
    WR_INIT = 2'd1,
    WR_CTRL = 2'd2,
    WR_NONE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    RD_DIV  = 2'd0,
    RD_INIT = 2'd1,
    RD_CUR  = 2'd2,
    RD_ZERO = 2'd3
  } rsel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } ctrl_t;

  function automatic logic [SHIFT_W-1:0] cfg_to_shift(input logic [DIVCFG_W-1:0] cfg);
    logic [SHIFT_W-1:0] v;
    v = {cfg[3], cfg[1:0]};
    return v + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int NTAP    = 2 ** SHIFT_W;
  localparam int PRESC_W = NTAP - 1;

  logic [PRESC_W-1:0] presc_q;
  logic [NTAP-1:0]    tap;

  always_ff @(posedge clk) begin
    if (!rst_n)         presc_q <= '0;
    else if (restart_i) presc_q <= '0;
    else                presc_q <= presc_q + 1'b1;
  end

  assign tap[0] = 1'b1;
  for (genvar s = 1; s < NTAP; s++) begin : g_tap
    assign tap[s] = &presc_q[s-1:0];
  end

  assign tick_o = tap[shift_i];

  // R4
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (presc_q == '0));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             masked_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic [CNT_W-1:0] count_o,
  output logic             fire_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             fire_q;
  logic [VEC_W-1:0] vec_q;
  logic             at_zero;
  logic             wrap;

  assign at_zero = (cnt_q == '0);
  assign wrap    = tick_i && at_zero && (reload_val_i != '0) && (periodic_i || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      if (!at_zero)
        cnt_q <= cnt_q - 1'b1;
      else if (periodic_i && reload_val_i != '0)
        cnt_q <= reload_val_i;
      if (wrap && !periodic_i)
        armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      fire_q <= !load_i && wrap && !masked_i;
      if (wrap) vec_q <= vector_i;
    end
  end

  assign count_o  = cnt_q;
  assign fire_o   = fire_q;
  assign vector_o = vec_q;

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> !$past(masked_i));
  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !at_zero) |=> (cnt_q <= $past(cnt_q)));
  // R5
  oneshot_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !periodic_i && at_zero) |=> (cnt_q == '0));
endmodule

// File: rtl/tick_countdown.sv
module tick_countdown
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire_pulse,
  output logic [VEC_W-1:0] expire_vector
);
  logic [DIVCFG_W-1:0] div_q;
  logic [CNT_W-1:0]    init_q;
  ctrl_t               ctrl_q;
  logic                load;
  logic                tick;
  logic [CNT_W-1:0]    cur_count;
  logic [SHIFT_W-1:0]  shift;

  assign load  = wr_en && (wsel_e'(wr_sel) == WR_INIT);
  assign shift = cfg_to_shift(div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      init_q <= '0;
      ctrl_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        WR_DIV:  div_q  <= wr_data[DIVCFG_W-1:0] & DIV_KEEP;
        WR_INIT: init_q <= wr_data;
        WR_CTRL: ctrl_q <= '{periodic: wr_data[PERIODIC_BIT],
                             masked:   wr_data[MASK_BIT],
                             vector:   wr_data[VEC_W-1:0]};
        default: ;
      endcase
    end
  end

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (load),
    .shift_i   (shift),
    .tick_o    (tick)
  );

  cdt_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .load_val_i   (wr_data),
    .reload_val_i (init_q),
    .tick_i       (tick),
    .periodic_i   (ctrl_q.periodic),
    .masked_i     (ctrl_q.masked),
    .vector_i     (ctrl_q.vector),
    .count_o      (cur_count),
    .fire_o       (expire_pulse),
    .vector_o     (expire_vector)
  );

  always_comb begin
    case (rsel_e'(rd_sel))
      RD_DIV:  rd_data = {{(CNT_W-DIVCFG_W){1'b0}}, div_q};
      RD_INIT: rd_data = init_q;
      RD_CUR:  rd_data = cur_count;
      default: rd_data = '0;
    endcase
  end

  // R8
  zero_init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && init_q == '0) |=> !expire_pulse);
endmodule

// File: tb/tick_countdown_bench.sv
`timescale 1ns/1ps
module tick_countdown_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        expire_pulse;
  logic [7:0]  expire_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tick_countdown u_tick_countdown (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .expire_pulse(expire_pulse), .expire_vector(expire_vector)
  );

  function automatic int exp_shift(input int cfg);
    int v;
    v = ((cfg >> 1) & 4) | (cfg & 3);
    return (v + 1) % 8;
  endfunction

  function automatic longint exp_count(input longint init, input int s, input longint k, input bit per);
    longint t;
    t = k >> s;
    if (per) return (init == 0) ? 0 : init - (t % (init + 1));
    return (t >= init) ? 0 : init - t;
  endfunction

  function automatic bit exp_pulse(input longint init, input int s, input longint k,
                                   input bit per, input bit msk);
    longint p, t;
    p = longint'(1) << s;
    if (init == 0 || msk || k == 0 || (k % p) != 0) return 1'b0;
    t = k / p;
    if (per) return (t % (init + 1)) == 0;
    return t == init + 1;
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int cfg, input int init, input bit per, input bit msk,
                     input int vec, input string tag);
    int s;
    longint len;
    s = exp_shift(cfg);
    wr(0, cfg);
    wr(2, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec & 8'hFF));
    wr(1, init);
    len = (longint'(init) + 1) * (longint'(1) << s) * 2 + (longint'(1) << s) + 2;
    rd_sel = 2'd1;
    #0.1;
    check("R4 init readback", rd_data, init);
    rd_sel = 2'd2;
    #0.1;
    check("R4 count at restart", rd_data, init);
    for (longint k = 0; k < len; k++) begin
      check(tag, rd_data, exp_count(init, s, k, per));
      check(tag, expire_pulse, exp_pulse(init, s, k, per, msk));
      if (expire_pulse && exp_pulse(init, s, k, per, msk))
        check("R10 vector", expire_vector, vec & 8'hFF);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      rd_sel = r[1:0];
      #0.1;
      check("R1 reset read", rd_data, 0);
    end
    check("R1 no pulse", expire_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(1, 3);
    // R1: the mask is set after reset, so no pulse appears
    for (int k = 0; k < 20; k++) begin
      check("R1 masked after reset", expire_pulse, 0);
      @(negedge clk);
    end
    // R2 keep bits 0,1,3
    wr(0, 32'hFFFF_FFFF);
    rd_sel = 2'd0; #0.1;
    check("R2 div keep mask", rd_data, 32'hB);
    wr(3, 32'h0000_0005);
    rd_sel = 2'd0; #0.1;
    check("R2 sel3 ignored div", rd_data, 32'hB);
    rd_sel = 2'd1; #0.1;
    check("R2 sel3 ignored init", rd_data, 3);
    // directed cases
    run(32'hB, 3, 1'b0, 1'b0, 8'h41, "R3 div1 oneshot");
    run(32'h0, 3, 1'b0, 1'b0, 8'h42, "R3 div2 oneshot");
    run(32'h8, 2, 1'b0, 1'b0, 8'h43, "R3 div32 oneshot");
    run(32'h3, 4, 1'b0, 1'b0, 8'h44, "R6 oneshot expiry");
    run(32'hB, 5, 1'b0, 1'b0, 8'h45, "R5 oneshot count");
    run(32'h1, 2, 1'b1, 1'b0, 8'h46, "R7 periodic");
    run(32'hB, 1, 1'b1, 1'b0, 8'h47, "R7 periodic init1");
    run(32'hB, 0, 1'b1, 1'b0, 8'h48, "R8 periodic zero");
    run(32'h0, 0, 1'b0, 1'b0, 8'h49, "R8 oneshot zero");
    run(32'hB, 3, 1'b1, 1'b1, 8'h4A, "R9 masked periodic");
    run(32'h2, 2, 1'b0, 1'b1, 8'h4B, "R9 masked oneshot");
    run(32'hA, 2, 1'b0, 1'b0, 8'hFF, "R10 vector");
    // random mix
    for (int i = 0; i < 40; i++) begin
      int cfg, init, per, msk, vec;
      cfg  = int'($urandom % 16);
      init = int'($urandom % 7);
      per  = int'($urandom % 2);
      msk  = (($urandom % 5) == 0) ? 1 : 0;
      vec  = int'($urandom % 256);
      run(cfg, init, per[0], msk[0], vec, per[0] ? "R7 random" : "R5 random");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule